// File: doc/BRIEF.md
# Fan PWM Generator with Rising and Falling Points

This block drives a bank of fan PWM outputs from a small set of shared clock types. Each clock type owns a two-stage prescaler and a period counter. The first stage divides the input clock by a power of two. The second stage divides it by a linear factor that is either one or an even number. The period counter then steps from 0 up to a programmable period value and wraps to 0. Every output picks one clock type. It goes high when that type's counter reaches the output's rising point, and it goes low when the counter reaches the output's falling point.

Software sets the block up through a plain write-only register port. A global run bit starts or stops every clock type. There is one control word for each group of four outputs, one configuration word for each clock type, and one 32-bit duty word for each pair of outputs. Period and duty changes are held in shadow copies and take effect only when the counter wraps, so a write in mid-period can never produce a runt pulse.

Top module: `fpwm_top`

Address map (word addresses): 0 is the run register. The next NUM_OUT/4 addresses are the group control words. The next NUM_TYPES addresses are the clock-type words. The last NUM_OUT/2 addresses are the duty words. With the defaults this gives run = 0, groups = 1 to 2, types = 3 to 5 and duty = 6 to 9.

## Requirements
- R1: A clock type with high field H, low field L and period field P (clock-type word bits [7:4], [3:0] and [15:8]) gives an output period of exactly 2^H × F_L × (P+1) input clock cycles.
- R2: The high divider field selects a factor of 2^H.
- R3: The low divider field gives a factor F_L of 1 when L = 0 and of 2×L otherwise.
- R4: Duty word k holds two outputs. Output 2k takes its rising point from bits [7:0] and its falling point from bits [15:8]. Output 2k+1 takes its rising point from bits [23:16] and its falling point from bits [31:24].
- R5: For a counter value c in a period, the output is high in these cases. If the falling point f is 0, it is high when c ≥ rising point r. If r < f, it is high when r ≤ c < f. If r > f > 0, it is high when c ≥ r or c < f. It is low for every c when r = f ≠ 0. Each high counter step lasts one full prescaled step.
- R6: With the output enabled, a rising point of 0 together with a falling point of 0 gives an output that is high all the time.
- R7: A rising point equal to a nonzero falling point gives an output that is low all the time.
- R8: An output whose enable bit is clear (bit 8+n of its group word, where n is the output's index within its group of four) is held low.
- R9: Output n of a group takes its 2-bit clock-type select with the low bit at bit 12+n and the high bit at bit 4+n of the group word. A select value with no matching clock type (3 with the default three types) holds the output low.
- R10: New duty and period values take effect only when the selected clock type's counter wraps. A pulse already in progress keeps its old length.
- R11: While the run bit (bit 0 of word 0) is clear, all outputs are low and every counter is held at 0. After run is set, the first prescaled step of every clock type is counter value 0.
- R12: After reset all outputs are low and the run bit is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock driving all prescalers |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| pwm_o | output | NUM_OUT | Fan PWM outputs |

## Verification
Each output's high time and rising-edge count are measured over whole periods. A prescaler stage that miscounts shows up in the first measured window as a wrong number of rising edges. A wrong decode of the rising or falling point shows up as a high time that is off by a multiple of the prescaled step. A shadow copy that loads at the wrong moment shows up within a single period, because the pulse in flight takes the new length instead of the old one. A counter that is not cleared while stopped shows up in the first pulse after restart, which comes out shorter than its programmed width.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
   localparam int unsigned FP_PT_W  = 8;
   localparam int unsigned FP_DIV_W = 4;
   localparam int unsigned FP_DW    = 32;

   typedef struct packed {
      logic [FP_PT_W-1:0]  per;
      logic [FP_DIV_W-1:0] hdiv;
      logic [FP_DIV_W-1:0] ldiv;
   } fp_tcfg_t;

   typedef struct packed {
      logic [FP_PT_W-1:0] fall;
      logic [FP_PT_W-1:0] rise;
   } fp_duty_t;

   function automatic logic fp_level(input logic [FP_PT_W-1:0] c,
                                     input logic [FP_PT_W-1:0] r,
                                     input logic [FP_PT_W-1:0] f);
      logic lv;
      if (f == '0)     lv = (c >= r);
      else if (r < f)  lv = (c >= r) && (c < f);
      else if (r == f) lv = 1'b0;
      else             lv = (c >= r) || (c < f);
      return lv;
   endfunction
endpackage

// File: rtl/fpwm_regs.sv
module fpwm_regs
   import fpwm_pkg::*;
#(
   parameter int unsigned NUM_OUT   = 8,
   parameter int unsigned NUM_TYPES = 3,
   parameter int unsigned ADDR_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [FP_DW-1:0]  wr_data,
   output logic              run_o,
   output logic [NUM_OUT-1:0] en_o,
   output logic [1:0]        sel_o  [NUM_OUT],
   output fp_tcfg_t          tcfg_o [NUM_TYPES],
   output fp_duty_t          duty_o [NUM_OUT]
);
   localparam int unsigned NUM_GRP = NUM_OUT / 4;
   localparam int unsigned NUM_DR  = NUM_OUT / 2;
   localparam int unsigned A_RUN   = 0;
   localparam int unsigned A_GRP   = A_RUN + 1;
   localparam int unsigned A_TYP   = A_GRP + NUM_GRP;
   localparam int unsigned A_DTY   = A_TYP + NUM_TYPES;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o <= 1'b0;
         en_o  <= '0;
         for (int i = 0; i < NUM_OUT; i++) begin
            sel_o[i]  <= '0;
            duty_o[i] <= '0;
         end
         for (int t = 0; t < NUM_TYPES; t++) tcfg_o[t] <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(A_RUN)) run_o <= wr_data[0];
         for (int g = 0; g < NUM_GRP; g++) begin
            if (wr_addr == ADDR_W'(A_GRP + g)) begin
               for (int n = 0; n < 4; n++) begin
                  en_o[4*g+n]  <= wr_data[8+n];
                  sel_o[4*g+n] <= {wr_data[4+n], wr_data[12+n]};
               end
            end
         end
         for (int t = 0; t < NUM_TYPES; t++) begin
            if (wr_addr == ADDR_W'(A_TYP + t)) tcfg_o[t] <= fp_tcfg_t'(wr_data[15:0]);
         end
         for (int d = 0; d < NUM_DR; d++) begin
            if (wr_addr == ADDR_W'(A_DTY + d)) begin
               duty_o[2*d]   <= fp_duty_t'(wr_data[15:0]);
               duty_o[2*d+1] <= fp_duty_t'(wr_data[31:16]);
            end
         end
      end
   end
endmodule

// File: rtl/fpwm_timebase.sv
module fpwm_timebase
   import fpwm_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  fp_tcfg_t           cfg_i,
   output logic [FP_PT_W-1:0] cnt_o,
   output logic               wrap_o,
   output logic [FP_PT_W-1:0] per_o
);
   localparam int unsigned HC_W = (1 << FP_DIV_W) - 1;
   localparam int unsigned LC_W = FP_DIV_W + 1;

   fp_tcfg_t        sh;
   logic [HC_W-1:0] c1, hlim;
   logic [LC_W-1:0] c2, llim;
   logic            t1, tick;

   always_comb begin
      hlim   = ~({HC_W{1'b1}} << sh.hdiv);
      llim   = (sh.ldiv == '0) ? '0 : ({sh.ldiv, 1'b0} - LC_W'(1));
      t1     = (c1 == hlim);
      tick   = t1 && (c2 == llim);
      wrap_o = tick && (cnt_o == sh.per);
      per_o  = sh.per;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         c1    <= '0;
         c2    <= '0;
         cnt_o <= '0;
      end else if (!run_i) begin
         sh    <= cfg_i;
         c1    <= '0;
         c2    <= '0;
         cnt_o <= '0;
      end else begin
         c1 <= t1 ? '0 : c1 + HC_W'(1);
         if (t1) c2 <= (c2 == llim) ? '0 : c2 + LC_W'(1);
         if (tick) cnt_o <= wrap_o ? '0 : cnt_o + FP_PT_W'(1);
         if (wrap_o) sh <= cfg_i;
      end
   end
endmodule

// File: rtl/fpwm_chan.sv
module fpwm_chan
   import fpwm_pkg::*;
#(
   parameter int unsigned NUM_TYPES = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic               en_i,
   input  logic [1:0]         sel_i,
   input  logic [FP_PT_W-1:0] cnt_i  [NUM_TYPES],
   input  logic [NUM_TYPES-1:0] wrap_i,
   input  fp_duty_t           duty_i,
   output fp_duty_t           duty_act_o,
   output logic               pwm_o
);
   logic               sel_ok, wrap_s;
   logic [FP_PT_W-1:0] cnt_s;

   always_comb begin
      sel_ok = ({1'b0, sel_i} < 3'(NUM_TYPES));
      cnt_s  = '0;
      wrap_s = 1'b0;
      for (int t = 0; t < NUM_TYPES; t++) begin
         if (sel_i == 2'(t)) begin
            cnt_s  = cnt_i[t];
            wrap_s = wrap_i[t];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_act_o <= '0;
         pwm_o      <= 1'b0;
      end else if (!run_i) begin
         duty_act_o <= duty_i;
         pwm_o      <= 1'b0;
      end else begin
         if (sel_ok && wrap_s) duty_act_o <= duty_i;
         pwm_o <= en_i && sel_ok && fp_level(cnt_s, duty_act_o.rise, duty_act_o.fall);
      end
   end
endmodule

// File: rtl/fpwm_top.sv
module fpwm_top
   import fpwm_pkg::*;
#(
   parameter int unsigned NUM_OUT   = 8,
   parameter int unsigned NUM_TYPES = 3,
   parameter int unsigned ADDR_W    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [FP_DW-1:0]   wr_data,
   output logic [NUM_OUT-1:0] pwm_o
);
   localparam int unsigned NUM_WORDS = 1 + NUM_OUT / 4 + NUM_TYPES + NUM_OUT / 2;

   if (NUM_OUT < 4 || (NUM_OUT % 4) != 0) begin : g_bad_out
      $error("NUM_OUT must be a nonzero multiple of 4");
   end
   if (NUM_TYPES < 1 || NUM_TYPES > 4) begin : g_bad_types
      $error("NUM_TYPES must be between 1 and 4");
   end
   if (NUM_WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic               run_w;
   logic [NUM_OUT-1:0] en_w;
   logic [1:0]         sel_w  [NUM_OUT];
   fp_tcfg_t           tcfg_w [NUM_TYPES];
   fp_duty_t           duty_r [NUM_OUT];
   fp_duty_t           duty_w [NUM_OUT];
   logic [FP_PT_W-1:0] cnt_w  [NUM_TYPES];
   logic [FP_PT_W-1:0] per_w  [NUM_TYPES];
   logic [NUM_TYPES-1:0] wrap_w;

   fpwm_regs #(.NUM_OUT(NUM_OUT), .NUM_TYPES(NUM_TYPES), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .run_o(run_w), .en_o(en_w), .sel_o(sel_w), .tcfg_o(tcfg_w), .duty_o(duty_r)
   );

   for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
      fpwm_timebase tb_i (
         .clk(clk), .rst_n(rst_n), .run_i(run_w), .cfg_i(tcfg_w[t]),
         .cnt_o(cnt_w[t]), .wrap_o(wrap_w[t]), .per_o(per_w[t])
      );
   end

   for (genvar n = 0; n < NUM_OUT; n++) begin : g_chan
      fpwm_chan #(.NUM_TYPES(NUM_TYPES)) ch_i (
         .clk(clk), .rst_n(rst_n), .run_i(run_w), .en_i(en_w[n]), .sel_i(sel_w[n]),
         .cnt_i(cnt_w), .wrap_i(wrap_w), .duty_i(duty_r[n]),
         .duty_act_o(duty_w[n]), .pwm_o(pwm_o[n])
      );
   end
endmodule

// File: rtl/fpwm_chk.sv
module fpwm_chk
   import fpwm_pkg::*;
#(
   parameter int unsigned NUM_OUT   = 8,
   parameter int unsigned NUM_TYPES = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               run,
   input logic [NUM_OUT-1:0] en,
   input logic [1:0]         sel  [NUM_OUT],
   input fp_duty_t           duty [NUM_OUT],
   input logic [FP_PT_W-1:0] cnt  [NUM_TYPES],
   input logic [FP_PT_W-1:0] per  [NUM_TYPES],
   input logic [NUM_OUT-1:0] pwm
);
   assert_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pwm == '0));

   for (genvar t = 0; t < NUM_TYPES; t++) begin : g_t
      assert_cnt_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !run |=> (cnt[t] == '0));
      assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
         run |-> (cnt[t] <= per[t]));
   end

   for (genvar n = 0; n < NUM_OUT; n++) begin : g_n
      assert_disabled_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (run && !en[n]) |=> !pwm[n]);
      assert_full_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (run && en[n] && ({1'b0, sel[n]} < 3'(NUM_TYPES)) &&
          duty[n].rise == '0 && duty[n].fall == '0) |=> pwm[n]);
      assert_equal_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (run && duty[n].fall != '0 && duty[n].rise == duty[n].fall) |=> !pwm[n]);
      assert_bad_sel_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (run && ({1'b0, sel[n]} >= 3'(NUM_TYPES))) |=> !pwm[n]);
   end
endmodule

bind fpwm_top fpwm_chk #(.NUM_OUT(NUM_OUT), .NUM_TYPES(NUM_TYPES)) chk_i (
   .clk(clk), .rst_n(rst_n), .run(run_w), .en(en_w), .sel(sel_w),
   .duty(duty_w), .cnt(cnt_w), .per(per_w), .pwm(pwm_o)
);

// File: tb/fpwm_top_tb_top.sv
module fpwm_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NOUT = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [NOUT-1:0] pwm_o;

   int checks = 0;
   int failures = 0;
   logic [31:0] grp_m [2];
   logic [31:0] duty_m [4];
   int tcur [3];

   always #(CLK_PERIOD/2) clk = ~clk;

   fpwm_top dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                   .wr_data(wr_data), .pwm_o(pwm_o));

   function automatic int div_of(int h, int l);
      return (1 << h) * ((l == 0) ? 1 : 2 * l);
   endfunction

   function automatic int hsteps(int r, int f, int p);
      int s = 0;
      for (int c = 0; c <= p; c++) begin
         if (f == 0) s += (c >= r) ? 1 : 0;
         else if (r < f) s += (c >= r && c < f) ? 1 : 0;
         else if (r > f) s += (c >= r || c < f) ? 1 : 0;
      end
      return s;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_type(input int t, input int h, input int l, input int p);
      wr(3 + t, {16'h0, p[7:0], h[3:0], l[3:0]});
   endtask

   task automatic set_chan(input int ch, input int sel, input int r, input int f, input bit en);
      int g = ch / 4;
      int n = ch % 4;
      int d = ch / 2;
      grp_m[g][8+n]  = en;
      grp_m[g][12+n] = sel[0];
      grp_m[g][4+n]  = sel[1];
      wr(1 + g, grp_m[g]);
      if (ch % 2 == 0) duty_m[d][15:0] = {f[7:0], r[7:0]};
      else             duty_m[d][31:16] = {f[7:0], r[7:0]};
      wr(6 + d, duty_m[d]);
   endtask

   task automatic measure(input int ch, input int ncyc, output int hi, output int rises);
      logic prev, cur;
      hi = 0; rises = 0;
      prev = pwm_o[ch];
      repeat (ncyc) begin
         @(negedge clk);
         cur = pwm_o[ch];
         if (cur) hi++;
         if (cur && !prev) rises++;
         prev = cur;
      end
   endtask

   task automatic run_case(input string tag, input int t, input int h, input int l, input int p,
                           input int ch, input int r, input int f);
      int tn, hs, hi, rs;
      tn = div_of(h, l) * (p + 1);
      set_type(t, h, l, p);
      set_chan(ch, t, r, f, 1'b1);
      repeat (tcur[t] + tn + 5) @(negedge clk);
      tcur[t] = tn;
      hs = hsteps(r, f, p);
      measure(ch, 2 * tn, hi, rs);
      chk({tag, " high cycles"}, hi, 2 * div_of(h, l) * hs);
      chk({tag, " rising edges"}, rs, (hs == 0 || hs == p + 1) ? 0 : 2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int hi, rs, len, tt, hh, ll, pp, rr, ff, cc;
      logic prev, cur;
      void'($urandom(32'd20240917));
      grp_m[0] = '0; grp_m[1] = '0;
      for (int i = 0; i < 4; i++) duty_m[i] = '0;
      for (int i = 0; i < 3; i++) tcur[i] = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 outputs after reset", int'(pwm_o), 0);

      // R11: configured but not running
      set_type(0, 0, 0, 3);
      for (int c = 0; c < NOUT; c++) set_chan(c, 0, 0, 0, 1'b1);
      repeat (10) @(negedge clk);
      chk("R11 outputs while stopped", int'(pwm_o), 0);
      chk("R12 run clear after reset", int'(pwm_o), 0);
      tcur[0] = 4;
      wr(0, 32'h1);

      run_case("R2", 0, 3, 0, 3, 0, 0, 2);
      run_case("R3 low=0", 0, 0, 0, 4, 0, 0, 2);
      run_case("R3 low=3", 0, 0, 3, 4, 0, 0, 2);
      run_case("R6", 0, 1, 1, 7, 6, 0, 0);
      run_case("R7", 0, 0, 1, 9, 7, 5, 5);
      run_case("R5 wrap form", 0, 0, 0, 9, 3, 7, 3);

      // R4: two outputs sharing one duty word
      set_type(0, 0, 0, 9);
      set_chan(2, 0, 0, 3, 1'b1);
      set_chan(3, 0, 5, 9, 1'b1);
      repeat (tcur[0] + 15) @(negedge clk);
      tcur[0] = 10;
      measure(2, 20, hi, rs);
      chk("R4 output 2k bits[15:0]", hi, 6);
      measure(3, 20, hi, rs);
      chk("R4 output 2k+1 bits[31:16]", hi, 8);

      // R8: disabled output
      set_chan(4, 0, 0, 0, 1'b0);
      repeat (15) @(negedge clk);
      measure(4, 30, hi, rs);
      chk("R8 disabled output high cycles", hi, 0);

      // R9: type selects
      run_case("R9 type1 group1", 1, 1, 0, 6, 5, 1, 4);
      run_case("R9 type2 group0", 2, 0, 0, 9, 1, 0, 3);
      set_chan(1, 3, 0, 3, 1'b1);
      repeat (5) @(negedge clk);
      measure(1, 40, hi, rs);
      chk("R9 reserved select high cycles", hi, 0);

      // R1 random configurations
      for (int it = 0; it < 16; it++) begin
         tt = $urandom % 3; hh = $urandom % 3; ll = $urandom % 4; pp = $urandom % 32;
         rr = $urandom % (pp + 3); ff = $urandom % (pp + 3); cc = $urandom % NOUT;
         run_case("R1 R5 random", tt, hh, ll, pp, cc, rr, ff);
      end

      // R10: change in mid-pulse takes effect at the wrap
      set_type(0, 0, 0, 99);
      set_chan(0, 0, 0, 50, 1'b1);
      repeat (tcur[0] + 105) @(negedge clk);
      tcur[0] = 100;
      prev = pwm_o[0];
      forever begin
         @(negedge clk);
         cur = pwm_o[0];
         if (cur && !prev) break;
         prev = cur;
      end
      len = 1;
      forever begin
         @(negedge clk);
         if (len == 5) begin
            duty_m[0][15:0] = {8'd80, 8'd0};
            wr_en = 1'b1; wr_addr = 4'd6; wr_data = duty_m[0];
         end else wr_en = 1'b0;
         if (pwm_o[0]) len++;
         else break;
      end
      wr_en = 1'b0;
      chk("R10 pulse in flight keeps old width", len, 50);
      prev = pwm_o[0];
      forever begin
         @(negedge clk);
         cur = pwm_o[0];
         if (cur && !prev) break;
         prev = cur;
      end
      len = 1;
      forever begin
         @(negedge clk);
         if (pwm_o[0]) len++;
         else break;
      end
      chk("R10 next pulse new width", len, 80);

      // R11: stop, then restart from count 0
      wr(0, 32'h0);
      repeat (2) @(negedge clk);
      chk("R11 outputs low after stop", int'(pwm_o), 0);
      duty_m[0][15:0] = {8'd10, 8'd0};
      wr(6, duty_m[0]);
      wr(0, 32'h1);
      len = 0;
      rs = 0;
      while (!pwm_o[0] && rs < 5) begin
         @(negedge clk);
         rs++;
      end
      chk("R11 first rise delay after restart", rs, 1);
      while (pwm_o[0]) begin
         len++;
         @(negedge clk);
      end
      chk("R11 first pulse width after restart", len, 10);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule